// File: doc/BRIEF.md
# Programmable LFSR Test Pattern Generator

This block produces stimulus vectors for a circuit under test. An n-stage linear feedback shift register advances once per enabled clock. A run-time coefficient input sets its feedback, so software or a test controller can switch the characteristic polynomial between test phases. A seed strobe reloads the register at any time. This reseeding helps reach faults that one long pseudorandom run leaves undetected.

A parameter picks the structure at build time. In the external form the feedback is a parity of selected stages, fed into stage 1. In the internal form the last stage is XORed into the stages between. A complete-mode input adds the all-zero state to the cycle, so that all 2^n vectors appear for exhaustive testing. In normal mode the register keeps out of the all-zero lock-up state. The whole vector is presented on a parallel output, and the last stage is presented on a serial output.

Control is a one-cycle action decoder with four named actions. It has no stored state.
- HOLD: nothing to do.
- SHIFT: advance one step.
- LOAD: take the seed.
- RECOVER: replace an all-zero state while in normal mode.

Each edge takes one action. The priority order is LOAD, then RECOVER, then SHIFT, then HOLD.

Top module: `lfsr_pattern_gen`

## Requirements
- R1: After reset, `pattern` equals DEFAULT_SEED (default 8'h01). `serial_out` always equals `pattern[WIDTH-1]`.
- R2: In the external form (FORM=0), one step gives {q[WIDTH-2:0], f}. Here f is the XOR of q[i-1] over every i with coefficient c_i = 1, and c_i is `poly[i-1]`.
- R3: In the internal form (FORM=1), one step uses f = q[WIDTH-1]. Bit 0 becomes f, and bit i (1..WIDTH-1) becomes q[i-1] XOR (f AND c_i).
- R4: With the primitive coefficient set 8'hB8 in normal mode, the sequence returns to its seed after exactly 255 steps. It never shows the all-zero vector. Over one period the serial stream has 128 ones and 127 zeros.
- R5: With `full_mode` = 1, the feedback bit is also inverted whenever q[WIDTH-2:0] is all zero. The sequence then passes through all 256 vectors, each exactly once, before it repeats.
- R6: A seed of zero loaded in normal mode is replaced by DEFAULT_SEED. In complete mode a zero seed is taken as is.
- R7: `seed_load` wins over `en` in the same cycle. The loaded value appears on `pattern` after the next rising edge, whether `en` is high or low.
- R8: With `en` low and no load, `pattern` does not change (the all-zero case of R10 excepted).
- R9: A change of `poly` takes effect on the very next step. `poly[WIDTH-1]` is ignored, because c_n is always treated as 1.
- R10: If the register holds all zeros while `full_mode` is 0, the next edge replaces it with DEFAULT_SEED, even with `en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the register one step per clock |
| seed_load | input | 1 | Load `seed_val` on this edge |
| seed_val | input | WIDTH | Seed to load |
| poly | input | WIDTH | Coefficients c_1..c_n at bits 0..WIDTH-1 (top bit ignored) |
| full_mode | input | 1 | Include the all-zero vector in the cycle |
| pattern | output | WIDTH | Current register contents, stage 1 at bit 0 |
| serial_out | output | 1 | Last stage of the register |

## Verification
Every result of this block is due one rising edge after the inputs that cause it, because `pattern` is the register itself. A load, a shift, a recovery or a polynomial change is visible after exactly one edge, and the serial bit is valid in the same cycle as the vector. The bench drives all inputs at the falling edge and compares at the next falling edge, so each comparison sees exactly one register update. It advances its reference model once per compared edge. Period counts come from the number of such edges until the seed reappears.

// File: rtl/lfsr_tpg_pkg.sv
package lfsr_tpg_pkg;

    // Action taken on one clock edge
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_LOAD    = 2'd2,
        OP_RECOVER = 2'd3
    } lfsr_op_e;

    localparam int FORM_EXTERNAL = 0;
    localparam int FORM_INTERNAL = 1;

endpackage

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
    import lfsr_tpg_pkg::*;
(
    input  logic     en,
    input  logic     seed_load,
    input  logic     full_mode,
    input  logic     state_zero,
    output lfsr_op_e op
);

    logic need_recover;

    assign need_recover = state_zero & ~full_mode;

    // Priority LOAD > RECOVER > SHIFT > HOLD, written as disjoint patterns
    always_comb begin
        unique casez ({seed_load, need_recover, en})
            3'b1??:  op = OP_LOAD;
            3'b01?:  op = OP_RECOVER;
            3'b001:  op = OP_SHIFT;
            3'b000:  op = OP_HOLD;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
    parameter int               WIDTH        = 8,
    parameter logic [WIDTH-1:0] DEFAULT_SEED = 1
) (
    input  logic [WIDTH-1:0] seed_in,
    input  logic             full_mode,
    output logic [WIDTH-1:0] seed_out
);

    logic seed_zero;

    assign seed_zero = ~|seed_in;

    always_comb begin
        if (seed_zero && !full_mode) begin
            seed_out = DEFAULT_SEED;
        end else begin
            seed_out = seed_in;
        end
    end

endmodule

// File: rtl/lfsr_step.sv
module lfsr_step
    import lfsr_tpg_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int FORM  = FORM_EXTERNAL
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] poly,
    input  logic             full_mode,
    output logic [WIDTH-1:0] nxt
);

    logic [WIDTH-1:0] taps;
    logic             low_zero;
    logic             zero_fix;

    // c_n is always present
    assign taps     = {1'b1, poly[WIDTH-2:0]};
    assign low_zero = ~|cur[WIDTH-2:0];
    assign zero_fix = full_mode & low_zero;

    generate
        if (FORM == FORM_EXTERNAL) begin : g_external
            logic fb;
            assign fb  = (^(cur & taps)) ^ zero_fix;
            assign nxt = {cur[WIDTH-2:0], fb};
        end else begin : g_internal
            logic fb;
            assign fb     = cur[WIDTH-1] ^ zero_fix;
            assign nxt[0] = fb;
            for (genvar i = 1; i < WIDTH; i++) begin : g_stage
                assign nxt[i] = cur[i-1] ^ (fb & taps[i-1]);
            end
        end
    endgenerate

endmodule

// File: rtl/lfsr_pattern_gen.sv
module lfsr_pattern_gen
    import lfsr_tpg_pkg::*;
#(
    parameter int               WIDTH        = 8,
    parameter int               FORM         = FORM_EXTERNAL,
    parameter logic [WIDTH-1:0] DEFAULT_SEED = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_val,
    input  logic [WIDTH-1:0] poly,
    input  logic             full_mode,
    output logic [WIDTH-1:0] pattern,
    output logic             serial_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] step_val;
    logic [WIDTH-1:0] seed_safe;
    logic             state_zero;
    lfsr_op_e         op;

    assign state_zero = ~|state_q;

    lfsr_ctrl u_ctrl (
        .en         (en),
        .seed_load  (seed_load),
        .full_mode  (full_mode),
        .state_zero (state_zero),
        .op         (op)
    );

    lfsr_step #(.WIDTH(WIDTH), .FORM(FORM)) u_step (
        .cur       (state_q),
        .poly      (poly),
        .full_mode (full_mode),
        .nxt       (step_val)
    );

    lfsr_seed_guard #(.WIDTH(WIDTH), .DEFAULT_SEED(DEFAULT_SEED)) u_guard (
        .seed_in   (seed_val),
        .full_mode (full_mode),
        .seed_out  (seed_safe)
    );

    // Register update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEFAULT_SEED;
        end else begin
            unique case (op)
                OP_LOAD:    state_q <= seed_safe;
                OP_RECOVER: state_q <= DEFAULT_SEED;
                OP_SHIFT:   state_q <= step_val;
                OP_HOLD:    state_q <= state_q;
            endcase
        end
    end

    // Outputs
    always_comb begin
        pattern    = state_q;
        serial_out = state_q[MSB];
    end

    // R7
    load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> pattern == ((($past(seed_val) != '0) || $past(full_mode))
                                  ? $past(seed_val) : DEFAULT_SEED));

    // R10
    no_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(full_mode) |-> pattern != '0);

    // R8
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !seed_load && (full_mode || pattern != '0)) |=> $stable(pattern));

    generate
        if (FORM == FORM_EXTERNAL) begin : g_ext_chk
            // R2
            ext_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en && !seed_load && !full_mode && pattern != '0)
                |=> pattern[MSB:1] == $past(pattern[MSB-1:0]));
        end else begin : g_int_chk
            // R3
            int_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en && !seed_load && !full_mode && pattern != '0)
                |=> pattern[0] == $past(pattern[MSB]));
        end
    endgenerate

endmodule

// File: tb/lfsr_pattern_gen_test.sv
module lfsr_pattern_gen_test;

    localparam int         W    = 8;
    localparam logic [7:0] DEFS = 8'h01;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       seed_load = 1'b0;
    logic [7:0] seed_val = '0;
    logic [7:0] poly = 8'hB8;
    logic       full_mode = 1'b0;
    logic [7:0] pat_e, pat_i;
    logic       ser_e, ser_i;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lfsr_pattern_gen #(.WIDTH(W), .FORM(0), .DEFAULT_SEED(DEFS)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load),
        .seed_val(seed_val), .poly(poly), .full_mode(full_mode),
        .pattern(pat_e), .serial_out(ser_e));

    lfsr_pattern_gen #(.WIDTH(W), .FORM(1), .DEFAULT_SEED(DEFS)) uut_int (
        .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load),
        .seed_val(seed_val), .poly(poly), .full_mode(full_mode),
        .pattern(pat_i), .serial_out(ser_i));

    // Reference step taken from R2, R3 and R5
    function automatic logic [7:0] ref_step(logic [7:0] q, logic [7:0] c,
                                             logic full, int form);
        logic [7:0] t, r;
        logic       f, z;
        t = {1'b1, c[6:0]};
        z = full && (q[6:0] == 7'd0);
        if (form == 0) begin
            f = z;
            for (int i = 0; i < 8; i++) f = f ^ (q[i] & t[i]);
            r = {q[6:0], f};
        end else begin
            f = q[7] ^ z;
            r[0] = f;
            for (int i = 1; i < 8; i++) r[i] = q[i-1] ^ (f & t[i-1]);
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(logic [7:0] s);
        @(negedge clk);
        seed_val  = s;
        seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset ext", pat_e, DEFS);
        chk("R1 reset int", pat_i, DEFS);
        chk("R1 serial ext", ser_e, pat_e[7]);
        chk("R1 serial int", ser_i, pat_i[7]);
    endtask

    // R2 R3 R4: period, no zero, ones balance
    task automatic t_period;
        logic [7:0] ee, ei;
        int pe, pi, ones_e, ones_i, zero_seen;
        full_mode = 1'b0;
        poly = 8'hB8;
        load(8'h5A);
        chk("R7 load ext", pat_e, 8'h5A);
        chk("R7 load int", pat_i, 8'h5A);
        ee = 8'h5A; ei = 8'h5A;
        pe = 0; pi = 0; ones_e = 0; ones_i = 0; zero_seen = 0;
        en = 1'b1;
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            ee = ref_step(ee, poly, 1'b0, 0);
            ei = ref_step(ei, poly, 1'b0, 1);
            chk("R2 step ext", pat_e, ee);
            chk("R3 step int", pat_i, ei);
            if (pat_e == 8'h00 || pat_i == 8'h00) zero_seen++;
            if (pe == 0) ones_e += ser_e;
            if (pi == 0) ones_i += ser_i;
            if (pe == 0 && pat_e == 8'h5A) pe = k;
            if (pi == 0 && pat_i == 8'h5A) pi = k;
            if (pe != 0 && pi != 0) break;
        end
        en = 1'b0;
        chk("R4 period ext", pe, 255);
        chk("R4 period int", pi, 255);
        chk("R4 no zero", zero_seen, 0);
        chk("R4 ones ext", ones_e, 128);
        chk("R4 ones int", ones_i, 128);
    endtask

    // R5: all 256 vectors once
    task automatic t_complete;
        logic [255:0] seen_e, seen_i;
        logic [7:0]   ee, ei;
        int dup;
        full_mode = 1'b1;
        load(8'h01);
        seen_e = '0; seen_i = '0; dup = 0;
        ee = 8'h01; ei = 8'h01;
        seen_e[8'h01] = 1'b1; seen_i[8'h01] = 1'b1;
        en = 1'b1;
        for (int k = 1; k < 256; k++) begin
            @(negedge clk);
            ee = ref_step(ee, poly, 1'b1, 0);
            ei = ref_step(ei, poly, 1'b1, 1);
            chk("R5 step ext", pat_e, ee);
            chk("R5 step int", pat_i, ei);
            if (seen_e[pat_e] || seen_i[pat_i]) dup++;
            seen_e[pat_e] = 1'b1;
            seen_i[pat_i] = 1'b1;
        end
        @(negedge clk);
        en = 1'b0;
        chk("R5 duplicates", dup, 0);
        chk("R5 coverage ext", $countones(seen_e), 256);
        chk("R5 coverage int", $countones(seen_i), 256);
        chk("R5 wrap ext", pat_e, 8'h01);
        chk("R5 wrap int", pat_i, 8'h01);
        full_mode = 1'b0;
    endtask

    // R6 zero seed handling
    task automatic t_zero_seed;
        full_mode = 1'b0;
        load(8'h00);
        chk("R6 zero seed normal ext", pat_e, DEFS);
        chk("R6 zero seed normal int", pat_i, DEFS);
        full_mode = 1'b1;
        load(8'h00);
        chk("R6 zero seed complete ext", pat_e, 8'h00);
        chk("R6 zero seed complete int", pat_i, 8'h00);
        en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        chk("R5 leave zero ext", pat_e, ref_step(8'h00, poly, 1'b1, 0));
        chk("R5 leave zero int", pat_i, ref_step(8'h00, poly, 1'b1, 1));
        full_mode = 1'b0;
    endtask

    // R7 load beats enable
    task automatic t_priority;
        @(negedge clk);
        en = 1'b1;
        seed_val = 8'hC3;
        seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
        en = 1'b0;
        chk("R7 priority ext", pat_e, 8'hC3);
        chk("R7 priority int", pat_i, 8'hC3);
    endtask

    // R8 hold
    task automatic t_hold;
        logic [7:0] he, hi;
        load(8'h3C);
        he = pat_e; hi = pat_i;
        poly = 8'h1D;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R8 hold ext", pat_e, he);
            chk("R8 hold int", pat_i, hi);
        end
        poly = 8'hB8;
    endtask

    // R9 run-time polynomial, top bit ignored
    task automatic t_poly;
        int pe, pi;
        poly = 8'h00;
        load(8'h01);
        pe = 0; pi = 0;
        en = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (pe == 0 && pat_e == 8'h01) pe = k;
            if (pi == 0 && pat_i == 8'h01) pi = k;
        end
        en = 1'b0;
        chk("R9 rotate period ext", pe, 8);
        chk("R9 rotate period int", pi, 8);
        load(8'h80);
        poly = 8'h1D;
        en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        chk("R9 new poly ext", pat_e, ref_step(8'h80, 8'h1D, 1'b0, 0));
        chk("R9 new poly int", pat_i, ref_step(8'h80, 8'h1D, 1'b0, 1));
        poly = 8'hB8;
    endtask

    // R10 leave complete mode at zero
    task automatic t_recover;
        full_mode = 1'b1;
        load(8'h00);
        chk("R10 zero held ext", pat_e, 8'h00);
        full_mode = 1'b0;
        @(negedge clk);
        chk("R10 recover ext", pat_e, DEFS);
        chk("R10 recover int", pat_i, DEFS);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_complete();
        t_zero_seed();
        t_priority();
        t_hold();
        t_poly();
        t_recover();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule